// File: doc/BRIEF.md
# Time-Slot Interchange Switch

This block is a non-blocking time-slot interchange for serial TDM traffic. Every input stream is shifted in bit by bit and cut into 8-bit channels. Each completed byte is stored in a data memory that has two halves and is swapped once per frame. For every output timeslot, a connection-memory entry picks one of two sources:

- the byte from any input stream and channel, taken from the half filled during the previous frame, or
- a constant byte held in the entry itself (message mode).

The same entry also decides whether the output driver is enabled for that timeslot.

All streams share one rate, chosen from four. The frame always spans 4096 cycles of the input clock, which runs at twice the fastest bit rate. The rate therefore sets both the bit period and the number of channels per frame. A frame pulse aligns the frame counter; when no pulse arrives, the counter wraps by itself. The stream count is the parameter `NUM_STREAMS`: sixteen in the full configuration, and four in the default build so that the flop memories stay small. At the top rate, four streams already carry 1024 channels. A simple synchronous register port writes and reads connection-memory entries. Output pins that double as bidirectional pads are modelled as a data output, an enable, and a separate pad input. In pad mode the pad input replaces the dedicated input.

Top module: `tsi_switch`

## Requirements
- R1: While `rst_n` is low, and after reset until an entry with its enable bit set is written, every `st_oe` bit is low and every connection entry reads back as zero.
- R2: With an entry `{oe=1, msg=0, stream=S, chan=C}` at output stream O, channel K, timeslot K of O carries the byte received on stream S, channel C during the previous frame.
- R3: `rate_sel` values 0, 1, 2 and 3 give 32, 64, 128 and 256 channels per frame, with bit periods of 16, 8, 4 and 2 clock cycles. Switching is correct at every rate.
- R4: Bytes are sent and received MSB first. An input bit is sampled at the middle cycle of its bit period. `st_out` changes only in the cycle right after a bit period starts, and stays stable for the rest of that period.
- R5: An entry with bit 12 (message) set makes its timeslot carry the entry's bits [7:0] in place of switched data. Neighbouring timeslots are unaffected.
- R6: An entry with bit 13 (enable) clear holds `st_oe` low for that whole timeslot. `st_oe` changes only at channel boundaries.
- R7: With `bidir_en` high, received data comes from `st_io_in`, and `st_in` has no effect on any output.
- R8: A frame pulse sampled high makes the next cycle frame cycle 0 and swaps the memory halves. Without pulses, the counter wraps after 4096 cycles and switching stays correct.
- R9: `cfg_we` writes `cfg_wdata` into entry `cfg_addr = {stream, channel}` at the clock edge. `cfg_rdata` shows the entry at the `cfg_addr` of the previous cycle. A read in the same cycle as a write to that address returns the old entry.
- R10: An entry written in the very cycle its timeslot is being loaded takes effect one frame later. The current timeslot still uses the old entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock, twice the fastest bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| fp_i | input | 1 | Frame pulse, one cycle high before frame cycle 0 |
| rate_sel | input | 2 | Stream rate select, 0 slowest to 3 fastest |
| bidir_en | input | 1 | Take received data from the pad inputs |
| st_in | input | NUM_STREAMS | Dedicated serial inputs |
| st_io_in | input | NUM_STREAMS | Pad-side inputs of the bidirectional pins |
| st_out | output | NUM_STREAMS | Serial output data |
| st_oe | output | NUM_STREAMS | Output driver enable, low means high impedance |
| cfg_we | input | 1 | Connection-memory write strobe |
| cfg_addr | input | log2(NUM_STREAMS)+8 | Entry address, stream in the upper bits |
| cfg_wdata | input | 14 | Entry: [13] enable, [12] message, [11:8] stream, [7:0] channel or byte |
| cfg_rdata | output | 14 | Registered entry read-back |

## Verification
Two events can land in the same cycle: a register-port write to a connection entry, and the fetch of that same entry when its timeslot starts loading. The bench provokes this by holding the write strobe in the exact frame cycle where the target channel's first bit period begins, using its own copy of the frame count. It then checks that the output byte in that frame is still the old message byte and that the new byte appears in the next frame. The register port also pairs a read with a write to the same address in one cycle; the bench checks that the old entry comes back first.

// File: rtl/tsi_pkg.sv
package tsi_pkg;

    localparam int CHAN_W  = 8;
    localparam int FCNT_W  = 12;
    localparam int BIDX_W  = FCNT_W - 1;

    typedef enum logic [1:0] {
        RATE_X1 = 2'd0,
        RATE_X2 = 2'd1,
        RATE_X4 = 2'd2,
        RATE_X8 = 2'd3
    } rate_e;

    typedef struct packed {
        logic        oe;
        logic        msg;
        logic [3:0]  src_stream;
        logic [7:0]  src_chan;
    } cm_entry_t;

endpackage

// File: rtl/tsi_frame_timer.sv
module tsi_frame_timer
    import tsi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fp_i,
    input  rate_e             rate_i,
    output logic [CHAN_W-1:0] chan_o,
    output logic [2:0]        bit_o,
    output logic              bit_start_o,
    output logic              sample_o,
    output logic              half_o
);

    typedef struct packed {
        logic [FCNT_W-1:0] fcnt;
        logic              half;
    } tmr_state_t;

    tmr_state_t tmr_d, tmr_q;

    logic [2:0]        shift;
    logic [FCNT_W-1:0] span;
    logic [FCNT_W-1:0] phase;
    logic [BIDX_W-1:0] bidx;

    always_comb begin
        tmr_d      = tmr_q;
        tmr_d.fcnt = fp_i ? '0 : tmr_q.fcnt + 1'b1;
        if (tmr_d.fcnt == '0) begin
            tmr_d.half = ~tmr_q.half;
        end

        shift = 3'd4 - 3'(rate_i);
        span  = FCNT_W'(1) << shift;
        phase = tmr_q.fcnt & (span - 1'b1);
        bidx  = BIDX_W'(tmr_q.fcnt >> shift);

        chan_o      = bidx[BIDX_W-1:3];
        bit_o       = bidx[2:0];
        bit_start_o = (phase == '0);
        sample_o    = (phase == (span >> 1));
        half_o      = tmr_q.half;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

endmodule

// File: rtl/tsi_rx_lane.sv
module tsi_rx_lane (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       din,
    input  logic       sample_i,
    input  logic [2:0] bit_i,
    output logic       wr_en_o,
    output logic [7:0] wr_byte_o
);

    typedef struct packed {
        logic [6:0] shreg;
    } rx_state_t;

    rx_state_t rx_d, rx_q;

    always_comb begin
        rx_d = rx_q;
        if (sample_i) begin
            rx_d.shreg = {rx_q.shreg[5:0], din};
        end
        wr_en_o   = sample_i && (bit_i == 3'd7);
        wr_byte_o = {rx_q.shreg, din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_q <= '0;
        end else begin
            rx_q <= rx_d;
        end
    end

endmodule

// File: rtl/tsi_tx_lane.sv
module tsi_tx_lane (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_start_i,
    input  logic [2:0] bit_i,
    input  logic [7:0] load_byte_i,
    input  logic       load_oe_i,
    output logic       dout_o,
    output logic       oe_o
);

    typedef struct packed {
        logic [7:0] byte_buf;
        logic       dout;
        logic       oe;
    } tx_state_t;

    tx_state_t tx_d, tx_q;

    always_comb begin
        tx_d = tx_q;
        if (bit_start_i) begin
            if (bit_i == 3'd0) begin
                tx_d.byte_buf = load_byte_i;
                tx_d.dout     = load_byte_i[7];
                tx_d.oe       = load_oe_i;
            end else begin
                tx_d.dout = tx_q.byte_buf[3'd7 - bit_i];
            end
        end
        dout_o = tx_q.dout;
        oe_o   = tx_q.oe;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q <= '0;
        end else begin
            tx_q <= tx_d;
        end
    end

endmodule

// File: rtl/tsi_switch.sv
module tsi_switch
    import tsi_pkg::*;
#(
    parameter int NUM_STREAMS = 4,
    localparam int SW     = $clog2(NUM_STREAMS),
    localparam int ADDR_W = SW + CHAN_W,
    localparam int CM_W   = $bits(cm_entry_t)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   fp_i,
    input  logic [1:0]             rate_sel,
    input  logic                   bidir_en,
    input  logic [NUM_STREAMS-1:0] st_in,
    input  logic [NUM_STREAMS-1:0] st_io_in,
    output logic [NUM_STREAMS-1:0] st_out,
    output logic [NUM_STREAMS-1:0] st_oe,
    input  logic                   cfg_we,
    input  logic [ADDR_W-1:0]      cfg_addr,
    input  logic [CM_W-1:0]        cfg_wdata,
    output logic [CM_W-1:0]        cfg_rdata
);

    localparam int NCH = 1 << CHAN_W;

    typedef struct packed {
        logic [CM_W-1:0] rdata;
    } port_state_t;

    port_state_t port_d, port_q;

    logic [CHAN_W-1:0] tm_chan;
    logic [2:0]        tm_bit;
    logic              tm_bit_start;
    logic              tm_sample;
    logic              tm_half;

    logic [NUM_STREAMS-1:0]        rx_din;
    logic [NUM_STREAMS-1:0]        rx_we;
    logic [NUM_STREAMS-1:0][7:0]   rx_byte;

    logic [7:0] dmem_q [2][NUM_STREAMS][NCH];
    cm_entry_t  cm_q   [NUM_STREAMS][NCH];

    logic [SW-1:0]     cfg_stream;
    logic [CHAN_W-1:0] cfg_chan;

    assign cfg_stream = cfg_addr[ADDR_W-1:CHAN_W];
    assign cfg_chan   = cfg_addr[CHAN_W-1:0];

    tsi_frame_timer u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .fp_i        (fp_i),
        .rate_i      (rate_e'(rate_sel)),
        .chan_o      (tm_chan),
        .bit_o       (tm_bit),
        .bit_start_o (tm_bit_start),
        .sample_o    (tm_sample),
        .half_o      (tm_half)
    );

    assign rx_din = bidir_en ? st_io_in : st_in;

    for (genvar s = 0; s < NUM_STREAMS; s++) begin : g_lane
        cm_entry_t     ent;
        logic [SW-1:0] src_s;
        logic [7:0]    ld_byte;
        logic          ld_oe;

        tsi_rx_lane u_rx (
            .clk       (clk),
            .rst_n     (rst_n),
            .din       (rx_din[s]),
            .sample_i  (tm_sample),
            .bit_i     (tm_bit),
            .wr_en_o   (rx_we[s]),
            .wr_byte_o (rx_byte[s])
        );

        always_comb begin
            ent     = cm_q[s][tm_chan];
            src_s   = SW'(ent.src_stream);
            ld_byte = ent.msg ? ent.src_chan : dmem_q[tm_half][src_s][ent.src_chan];
            ld_oe   = ent.oe;
        end

        tsi_tx_lane u_tx (
            .clk         (clk),
            .rst_n       (rst_n),
            .bit_start_i (tm_bit_start),
            .bit_i       (tm_bit),
            .load_byte_i (ld_byte),
            .load_oe_i   (ld_oe),
            .dout_o      (st_out[s]),
            .oe_o        (st_oe[s])
        );
    end

    always_ff @(posedge clk) begin
        for (int s = 0; s < NUM_STREAMS; s++) begin
            if (rx_we[s]) begin
                dmem_q[~tm_half][s][tm_chan] <= rx_byte[s];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_STREAMS; i++) begin
                for (int j = 0; j < NCH; j++) begin
                    cm_q[i][j] <= '0;
                end
            end
        end else if (cfg_we) begin
            cm_q[cfg_stream][cfg_chan] <= cm_entry_t'(cfg_wdata);
        end
    end

    always_comb begin
        port_d       = port_q;
        port_d.rdata = CM_W'(cm_q[cfg_stream][cfg_chan]);
        cfg_rdata    = port_q.rdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            port_q <= '0;
        end else begin
            port_q <= port_d;
        end
    end

endmodule

// File: rtl/tsi_switch_chk.sv
module tsi_switch_chk #(
    parameter int NUM_STREAMS = 4,
    parameter int ADDR_W      = 10,
    parameter int CM_W        = 14
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   fp_i,
    input logic [NUM_STREAMS-1:0] st_out,
    input logic [NUM_STREAMS-1:0] st_oe,
    input logic                   cfg_we,
    input logic [ADDR_W-1:0]      cfg_addr,
    input logic [CM_W-1:0]        cfg_wdata,
    input logic [CM_W-1:0]        cfg_rdata,
    input logic                   tm_bit_start,
    input logic [2:0]             tm_bit,
    input logic                   tm_half
);

    // R1: drivers stay off while reset is held
    always @(negedge clk) begin
        if (!rst_n) begin
            assert_oe_off_in_reset_R1: assert (st_oe == '0)
                else $error("st_oe active during reset");
        end
    end

    // R4: data pins move only right after a bit period starts
    assert_out_moves_on_bit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st_out) |-> $past(tm_bit_start));

    // R6: enables move only at a channel boundary
    assert_oe_on_channel_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st_oe) |-> $past(tm_bit_start && (tm_bit == 3'd0)));

    // R8: a frame pulse flips the buffer halves
    assert_pulse_swaps_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fp_i |=> (tm_half != $past(tm_half)));

    // R9: a write followed by a read of the same entry returns the written value
    assert_readback_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we ##1 (!cfg_we && (cfg_addr == $past(cfg_addr)))) |=> (cfg_rdata == $past(cfg_wdata, 2)));

endmodule

bind tsi_switch tsi_switch_chk #(
    .NUM_STREAMS (NUM_STREAMS),
    .ADDR_W      (ADDR_W),
    .CM_W        (CM_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .fp_i         (fp_i),
    .st_out       (st_out),
    .st_oe        (st_oe),
    .cfg_we       (cfg_we),
    .cfg_addr     (cfg_addr),
    .cfg_wdata    (cfg_wdata),
    .cfg_rdata    (cfg_rdata),
    .tm_bit_start (tm_bit_start),
    .tm_bit       (tm_bit),
    .tm_half      (tm_half)
);

// File: tb/test_tsi_switch.sv
module test_tsi_switch;

    localparam int NS  = 4;
    localparam int SWB = 2;
    localparam int AW  = SWB + 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          fp_i = 1'b0;
    logic [1:0]    rate_sel = 2'd3;
    logic          bidir_en = 1'b0;
    logic [NS-1:0] st_in = '0;
    logic [NS-1:0] st_io_in = '0;
    logic [NS-1:0] st_out;
    logic [NS-1:0] st_oe;
    logic          cfg_we = 1'b0;
    logic [AW-1:0] cfg_addr = '0;
    logic [13:0]   cfg_wdata = '0;
    logic [13:0]   cfg_rdata;

    tsi_switch #(.NUM_STREAMS(NS)) i_tsi_switch (
        .clk       (clk),
        .rst_n     (rst_n),
        .fp_i      (fp_i),
        .rate_sel  (rate_sel),
        .bidir_en  (bidir_en),
        .st_in     (st_in),
        .st_io_in  (st_io_in),
        .st_out    (st_out),
        .st_oe     (st_oe),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata)
    );

    always #5 clk = ~clk;

    logic [7:0] tx_d  [NS][256];
    logic [7:0] tx_io [NS][256];
    logic [7:0] rx_d  [NS][256];
    logic       rx_oe [NS][256];

    int  n_chk = 0;
    int  n_fail = 0;
    int  bc = 4095;
    int  frames = 0;
    int  glitches = 0;
    bit  running = 1'b0;
    bit  no_fp = 1'b0;
    int  g_sh, g_p, g_ph, g_bi, g_ch, g_b;

    always @(posedge clk) begin
        if (!running) begin
            bc <= 4095;
        end else begin
            bc <= (bc + 1) & 4095;
            if (bc == 4095) frames <= frames + 1;
        end
    end

    always @(negedge clk) begin
        if (running) begin
            g_sh = 4 - int'(rate_sel);
            g_p  = 1 << g_sh;
            g_ph = bc & (g_p - 1);
            g_bi = bc >> g_sh;
            g_ch = g_bi >> 3;
            g_b  = g_bi & 7;
            fp_i = (bc == 4095) && !no_fp;
            for (int s = 0; s < NS; s++) begin
                st_in[s]    = tx_d[s][g_ch][7 - g_b];
                st_io_in[s] = tx_io[s][g_ch][7 - g_b];
                if (g_ph == g_p / 2) begin
                    rx_d[s][g_ch][7 - g_b] = st_out[s];
                    if (g_b == 0) rx_oe[s][g_ch] = st_oe[s];
                end
                if (g_ph == g_p - 1 && st_out[s] !== rx_d[s][g_ch][7 - g_b]) glitches++;
            end
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [13:0] mk(input bit oe, input bit msg, input int ss, input int sc);
        return {oe, msg, 4'(ss), 8'(sc)};
    endfunction

    function automatic logic [7:0] pat(input int s, input int c, input int seed);
        return 8'(s * 37 + c * 11 + seed);
    endfunction

    task automatic cm_write(input int s, input int c, input logic [13:0] e);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_addr  = {SWB'(s), 8'(c)};
        cfg_wdata = e;
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    task automatic wait_frames(input int n);
        int target;
        target = frames + n;
        while (frames < target) @(posedge clk);
        #1;
    endtask

    task automatic restore(input int s, input int c);
        cm_write(s, c, mk(1, 0, (s + 1) % NS, (c * 5 + 3) % 256));
    endtask

    task automatic compare_map(input int nch, input bit use_io, input string tag);
        for (int s = 0; s < NS; s++) begin
            for (int c = 0; c < nch; c++) begin
                int src, sc;
                logic [7:0] e;
                src = (s + 1) % NS;
                sc  = (c * 5 + 3) % nch;
                e   = use_io ? tx_io[src][sc] : tx_d[src][sc];
                check(rx_d[s][c] == e, tag, rx_d[s][c], e);
            end
            check(rx_oe[s][0] == 1'b1, {tag, " enable"}, rx_oe[s][0], 1);
        end
    endtask

    task automatic t_reset;
        int on;
        check(st_oe == '0, "R1 st_oe after reset", st_oe, 0);
        @(negedge clk);
        cfg_addr = {SWB'(2), 8'd77};
        @(negedge clk);
        @(negedge clk);
        check(cfg_rdata == '0, "R1 entry cleared", cfg_rdata, 0);
        running = 1'b1;
        wait_frames(2);
        on = 0;
        for (int s = 0; s < NS; s++)
            for (int c = 0; c < 256; c++) on += int'(rx_oe[s][c]);
        check(on == 0, "R1 no enable without programming", on, 0);
    endtask

    task automatic t_switch(input int r);
        int nch;
        nch = 32 << r;
        rate_sel = 2'(r);
        for (int s = 0; s < NS; s++)
            for (int c = 0; c < 256; c++) tx_d[s][c] = pat(s, c, r * 17 + 1);
        for (int s = 0; s < NS; s++)
            for (int c = 0; c < nch; c++) cm_write(s, c, mk(1, 0, (s + 1) % NS, (c * 5 + 3) % nch));
        glitches = 0;
        wait_frames(3);
        compare_map(nch, 1'b0, $sformatf("R2 R3 rate%0d", r));
        check(glitches == 0, "R4 output stable within bit", glitches, 0);
    endtask

    task automatic t_wrap;
        no_fp = 1'b1;
        for (int s = 0; s < NS; s++)
            for (int c = 0; c < 256; c++) tx_d[s][c] = pat(s, c, 200);
        wait_frames(3);
        compare_map(256, 1'b0, "R8 free-running wrap");
        no_fp = 1'b0;
    endtask

    task automatic t_msg;
        cm_write(1, 10, mk(1, 1, 0, 8'hA5));
        cm_write(2, 200, mk(1, 1, 3, 8'h3C));
        wait_frames(3);
        check(rx_d[1][10] == 8'hA5, "R5 message byte", rx_d[1][10], 8'hA5);
        check(rx_d[2][200] == 8'h3C, "R5 message byte", rx_d[2][200], 8'h3C);
        check(rx_d[1][11] == tx_d[2][(11 * 5 + 3) % 256], "R5 neighbour switched",
              rx_d[1][11], tx_d[2][(11 * 5 + 3) % 256]);
        restore(1, 10);
        restore(2, 200);
    endtask

    task automatic t_oe;
        cm_write(0, 20, mk(0, 0, 1, 5));
        cm_write(3, 255, mk(0, 1, 0, 8'hFF));
        wait_frames(2);
        check(rx_oe[0][20] == 1'b0, "R6 disabled slot", rx_oe[0][20], 0);
        check(rx_oe[3][255] == 1'b0, "R6 disabled message slot", rx_oe[3][255], 0);
        check(rx_oe[0][21] == 1'b1, "R6 neighbour enabled", rx_oe[0][21], 1);
        restore(0, 20);
        restore(3, 255);
    endtask

    task automatic t_cfg;
        cm_write(2, 77, 14'h2ABC);
        @(negedge clk);
        cfg_addr = {SWB'(2), 8'd77};
        @(negedge clk);
        check(cfg_rdata == 14'h2ABC, "R9 read-back", cfg_rdata, 14'h2ABC);
        cfg_we    = 1'b1;
        cfg_wdata = 14'h1234;
        @(negedge clk);
        check(cfg_rdata == 14'h2ABC, "R9 old entry on same-cycle write", cfg_rdata, 14'h2ABC);
        cfg_we = 1'b0;
        @(negedge clk);
        check(cfg_rdata == 14'h1234, "R9 new entry after write", cfg_rdata, 14'h1234);
        restore(2, 77);
    endtask

    task automatic t_collide;
        cm_write(1, 40, mk(1, 1, 0, 8'h11));
        wait_frames(2);
        @(negedge clk);
        while (bc != 40 * 8 * 2) @(negedge clk);
        cfg_we    = 1'b1;
        cfg_addr  = {SWB'(1), 8'd40};
        cfg_wdata = mk(1, 1, 0, 8'h22);
        @(negedge clk);
        cfg_we = 1'b0;
        wait_frames(1);
        check(rx_d[1][40] == 8'h11, "R10 old entry in load frame", rx_d[1][40], 8'h11);
        wait_frames(1);
        check(rx_d[1][40] == 8'h22, "R10 new entry next frame", rx_d[1][40], 8'h22);
        restore(1, 40);
    endtask

    task automatic t_bidir;
        for (int s = 0; s < NS; s++)
            for (int c = 0; c < 256; c++) begin
                tx_io[s][c] = pat(s, c, 99);
                tx_d[s][c]  = ~pat(s, c, 7);
            end
        bidir_en = 1'b1;
        wait_frames(3);
        compare_map(256, 1'b1, "R7 pad input used");
        bidir_en = 1'b0;
    endtask

    initial begin
        for (int s = 0; s < NS; s++)
            for (int c = 0; c < 256; c++) begin
                tx_d[s][c] = '0; tx_io[s][c] = '0; rx_d[s][c] = '0; rx_oe[s][c] = 1'b0;
            end
        repeat (5) @(posedge clk);
        #1;
        check(st_oe == '0, "R1 st_oe during reset", st_oe, 0);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        for (int r = 0; r < 4; r++) t_switch(r);
        t_wrap();
        t_msg();
        t_oe();
        t_cfg();
        t_collide();
        t_bidir();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (195000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule